// File: doc/BRIEF.md
# Bitfield Insert Execution Unit

This unit decodes and executes a single bitfield insert instruction. The operation takes a contiguous run of bits from the destination register value and overwrites it with the low-order bits of the source register value. Every destination bit outside that run keeps its value. The instruction word can arrive in either of two 32-bit layouts. A select input says which layout applies. Both layouts describe the field by its top and bottom bit positions rather than by a width.

Alongside the instruction word, the surrounding pipeline supplies the current destination value, the source value, and a condition-passed bit from the external condition evaluator. The unit returns four things one clock later: the merged value, the destination register index, a write enable, and an invalid-encoding flag. It touches no status flags and has no port that could write them. The register file and the fetch logic sit outside the unit.

Top module: `bfins_unit`

## Requirements
- R1: With `in_fmt_alt`=0 (primary layout), the fields are at fixed positions. The source index is in bits 3:0, the bottom position in bits 11:7, the destination index in bits 15:12 and the top position in bits 20:16. Bits 27:21 must equal 0111110 and bits 6:4 must equal 001. Bits 31:28 are ignored.
- R2: With `in_fmt_alt`=1 (alternate layout), bits 31:20 must equal 0xF36, and bits 15 and 5 must both be 0. The source index is in bits 19:16 and the destination index in bits 11:8. The top position is in bits 4:0. The bottom position is bits 14:12 followed by bits 7:6, with bits 14:12 as its upper three bits.
- R3: For a valid encoding, every bit of `out_data` below the bottom position or above the top position equals the same bit of `in_dst_val`.
- R4: For a valid encoding, bits top..bottom of `out_data` hold bits (top−bottom)..0 of `in_src_val`. Source bits above the field width have no effect.
- R5: When `in_cond_pass` is 0, `out_we` stays 0. `out_invalid` is still reported from the encoding alone.
- R6: A top position below the bottom position raises `out_invalid` and keeps `out_we` at 0.
- R7: A source index of 15 raises `out_invalid` and keeps `out_we` at 0.
- R8: A word whose fixed bits do not match the selected layout raises `out_invalid` and keeps `out_we` at 0.
- R9: `out_valid` is `in_valid` delayed by exactly one clock. The unit accepts a new instruction every cycle. `out_rd` carries the decoded destination index.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_we` and `out_invalid` are cleared.
- R11: A single-bit field (top equal to bottom) and the full 32-bit field (bottom 0, top 31) are both merged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 32 | Instruction word |
| in_fmt_alt | input | 1 | 0 = primary layout, 1 = alternate layout |
| in_cond_pass | input | 1 | Condition evaluated true |
| in_dst_val | input | 32 | Current destination register value |
| in_src_val | input | 32 | Source register value |
| out_valid | output | 1 | Result present |
| out_we | output | 1 | Destination write enable |
| out_invalid | output | 1 | Encoding rejected |
| out_rd | output | 4 | Destination register index |
| out_data | output | 32 | Merged destination value |

## Verification
Several groups of stimulus exercise the merge. Mid-word fields in each layout separate correct field slicing from swapped or mis-positioned fields. Single-bit fields at bit 31 and at bit 0, together with the full-width field, expose off-by-one errors at the mask edges. An all-ones source with a narrow field shows whether source bits above the width leak into the result. Words that break each fixed bit, top-below-bottom pairs, and source index 15 each check that the invalid flag rises and the write is dropped. A condition-failed case confirms that the write gate is independent of the flag. Back-to-back issue followed by an idle gap checks the one-cycle valid timing.

// File: rtl/bfins_pkg.sv
// Package: shared widths and the decoded-field record for the bitfield
// insert unit. Assumes 32-bit instruction words and 16 registers.
package bfins_pkg;
    localparam int INSN_W = 32;
    localparam int DATA_W = 32;
    localparam int POS_W  = $clog2(DATA_W);
    localparam int IDX_W  = 4;

    typedef struct packed {
        logic             fixed_ok;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rd;
        logic [POS_W-1:0] lsb;
        logic [POS_W-1:0] msb;
    } bf_fields_t;
endpackage

// File: rtl/bfins_slice.sv
// Module: slices one instruction layout into register indices and field
// positions, and checks that layout's fixed bits. ALT_LAYOUT chooses which
// layout this instance decodes. Purely combinational; assumes 32-bit words.
module bfins_slice
    import bfins_pkg::*;
#(
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic [INSN_W-1:0] insn,
    output bf_fields_t        fields
);
    generate
        if (ALT_LAYOUT) begin : g_alt
            // Alternate layout: bottom position split over two fragments.
            always_comb begin
                fields.fixed_ok = (insn[31:20] == 12'hF36) && !insn[15] && !insn[5];
                fields.rn       = insn[19:16];
                fields.rd       = insn[11:8];
                fields.lsb      = {insn[14:12], insn[7:6]};
                fields.msb      = insn[4:0];
            end
        end else begin : g_pri
            logic unused_cond;
            // The condition field is evaluated outside this unit.
            assign unused_cond = ^insn[31:28];
            // Primary layout: contiguous fields.
            always_comb begin
                fields.fixed_ok = (insn[27:21] == 7'b0111110) && (insn[6:4] == 3'b001);
                fields.rn       = insn[3:0];
                fields.rd       = insn[15:12];
                fields.lsb      = insn[11:7];
                fields.msb      = insn[20:16];
            end
        end
    endgenerate
endmodule

// File: rtl/bfins_merge.sv
// Module: builds the field mask from bottom/top positions and merges the
// shifted source into the destination. Combinational. When msb < lsb the
// mask is empty, and the caller flags the encoding as invalid.
module bfins_merge
    import bfins_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int PW = POS_W
) (
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [PW-1:0] lsb,
    input  logic [PW-1:0] msb,
    output logic [W-1:0]  mask,
    output logic [W-1:0]  merged
);
    logic [W-1:0] shifted;

    // Source aligned so its bit 0 sits at the bottom position.
    assign shifted = src << lsb;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // One mask bit: set when this position lies inside the field.
            assign mask[gi] = (PW'(gi) >= lsb) && (PW'(gi) <= msb);
        end
    endgenerate

    // Keep outside bits, take inside bits from the aligned source.
    assign merged = (dst & ~mask) | (shifted & mask);
endmodule

// File: rtl/bfins_unit.sv
// Module: top of the bitfield insert unit. Decodes both layouts, picks one
// with in_fmt_alt, validates the fields, merges, and registers the result
// with one cycle of latency. Assumes the caller supplies register values
// already read. No flag outputs exist, so no flag update is possible.
module bfins_unit
    import bfins_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic              in_fmt_alt,
    input  logic              in_cond_pass,
    input  logic [DATA_W-1:0] in_dst_val,
    input  logic [DATA_W-1:0] in_src_val,
    output logic              out_valid,
    output logic              out_we,
    output logic              out_invalid,
    output logic [IDX_W-1:0]  out_rd,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [IDX_W-1:0] RSVD_IDX = {IDX_W{1'b1}};

    bf_fields_t        pri_f, alt_f, sel_f;
    logic              enc_bad;
    logic [DATA_W-1:0] fmask, merged;

    bfins_slice #(.ALT_LAYOUT(1'b0)) u_pri (.insn(in_insn), .fields(pri_f));
    bfins_slice #(.ALT_LAYOUT(1'b1)) u_alt (.insn(in_insn), .fields(alt_f));

    // Choose the layout named by the format select.
    assign sel_f = in_fmt_alt ? alt_f : pri_f;

    // Reject bad fixed bits, a reversed field, or the reserved source slot.
    assign enc_bad = !sel_f.fixed_ok || (sel_f.msb < sel_f.lsb) || (sel_f.rn == RSVD_IDX);

    bfins_merge #(.W(DATA_W), .PW(POS_W)) u_merge (
        .dst    (in_dst_val),
        .src    (in_src_val),
        .lsb    (sel_f.lsb),
        .msb    (sel_f.msb),
        .mask   (fmask),
        .merged (merged)
    );

    // Control outputs: reset-cleared valid, write enable and invalid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_we      <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_we      <= in_valid && in_cond_pass && !enc_bad;
            out_invalid <= in_valid && enc_bad;
        end
    end

    // Data outputs: captured only when an instruction is presented.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_data <= merged;
            out_rd   <= sel_f.rd;
        end
    end

    // Assertions, each next to the logic it guards.
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r5_cond_gates_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cond_pass) |=> !out_we);
    a_r6_reversed_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sel_f.msb < sel_f.lsb)) |=> (out_invalid && !out_we));
    a_r7_reserved_src: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sel_f.rn == RSVD_IDX)) |=> (out_invalid && !out_we));
    a_r8_pri_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fmt_alt && (in_insn[6:4] != 3'b001)) |=> out_invalid);
    a_r2_alt_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt_alt && (in_insn[15] || in_insn[5])) |=> out_invalid);
    a_r8_no_write_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (!out_we && out_valid));
    a_r3_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_bad |-> (((merged ^ in_dst_val) & ~fmask) == '0));
    a_r4_inside_from_src: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_bad |-> (((merged ^ (in_src_val << sel_f.lsb)) & fmask) == '0));
endmodule

// File: tb/bfins_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results into a queue, and a
// monitor pops and compares each result that the unit produces.
module bfins_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic        in_fmt_alt = 1'b0;
    logic        in_cond_pass = 1'b0;
    logic [31:0] in_dst_val = '0;
    logic [31:0] in_src_val = '0;
    logic        out_valid, out_we, out_invalid;
    logic [3:0]  out_rd;
    logic [31:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic        we;
        logic        inv;
        logic [3:0]  rd;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bfins_unit u_bfins_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_fmt_alt(in_fmt_alt), .in_cond_pass(in_cond_pass),
        .in_dst_val(in_dst_val), .in_src_val(in_src_val),
        .out_valid(out_valid), .out_we(out_we), .out_invalid(out_invalid),
        .out_rd(out_rd), .out_data(out_data)
    );

    function automatic logic [31:0] enc_pri(input logic [3:0] c, input logic [4:0] m,
                                            input logic [3:0] d, input logic [4:0] l,
                                            input logic [3:0] n);
        return {c, 7'b0111110, m, d, l, 3'b001, n};
    endfunction

    function automatic logic [31:0] enc_alt(input logic [3:0] n, input logic [3:0] d,
                                            input logic [4:0] l, input logic [4:0] m);
        return {12'hF36, n, 1'b0, l[4:2], d, l[1:0], 1'b0, m};
    endfunction

    // Bit-by-bit reference merge derived from R3/R4.
    function automatic logic [31:0] ref_merge(input logic [31:0] d, input logic [31:0] s,
                                              input int l, input int m);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i >= l && i <= m) ? s[i-l] : d[i];
        return r;
    endfunction

    task automatic report(input bit ok, input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: presents one instruction in the next cycle and queues its expectation.
    task automatic issue(input logic [31:0] w, input logic alt, input logic [31:0] dv,
                         input logic [31:0] sv, input logic cp, input logic [3:0] n,
                         input logic [3:0] d, input int l, input int m,
                         input logic fixed_ok, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_insn = w; in_fmt_alt = alt; in_cond_pass = cp;
        in_dst_val = dv; in_src_val = sv;
        e.inv  = !fixed_ok || (m < l) || (n == 4'hF);
        e.we   = cp && !e.inv;
        e.rd   = d;
        e.data = ref_merge(dv, sv, l, m);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares every produced result with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sb_q.size() == 0) begin
                report(1'b0, "R9", "unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                report(out_we == e.we, e.tag, "out_we", 32'(out_we), 32'(e.we));
                report(out_invalid == e.inv, e.tag, "out_invalid", 32'(out_invalid), 32'(e.inv));
                if (!e.inv) begin
                    report(out_rd == e.rd, e.tag, "out_rd", 32'(out_rd), 32'(e.rd));
                    report(out_data == e.data, e.tag, "out_data", out_data, e.data);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        // R10: reset clears the control outputs.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        report({out_valid, out_we, out_invalid} == 3'b000, "R10", "reset outputs",
               32'({out_valid, out_we, out_invalid}), 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1, R3: primary layout, mid-word field.
        issue(enc_pri(4'hE, 5'd15, 4'd3, 5'd8, 4'd2), 1'b0, 32'h1234_5678, 32'h0000_00AB,
              1'b1, 4'd2, 4'd3, 8, 15, 1'b1, "R1");
        // R1: condition field bits 31:28 ignored, back to back (R9).
        issue(enc_pri(4'h0, 5'd27, 4'd7, 5'd20, 4'd1), 1'b0, 32'hFFFF_FFFF, 32'h0000_0000,
              1'b1, 4'd1, 4'd7, 20, 27, 1'b1, "R9");
        // R11: full width and single bit at both ends.
        issue(enc_pri(4'hE, 5'd31, 4'd4, 5'd0, 4'd5), 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D,
              1'b1, 4'd5, 4'd4, 0, 31, 1'b1, "R11");
        issue(enc_pri(4'hE, 5'd31, 4'd6, 5'd31, 4'd5), 1'b0, 32'h0000_0000, 32'h0000_0001,
              1'b1, 4'd5, 4'd6, 31, 31, 1'b1, "R11");
        issue(enc_alt(4'd3, 4'd9, 5'd0, 5'd0), 1'b1, 32'hFFFF_FFFF, 32'h0000_0000,
              1'b1, 4'd3, 4'd9, 0, 0, 1'b1, "R11");
        // R2: alternate layout, bottom position split across fragments.
        issue(enc_alt(4'd2, 4'd12, 5'd13, 5'd23), 1'b1, 32'hA5A5_A5A5, 32'h0000_05C3,
              1'b1, 4'd2, 4'd12, 13, 23, 1'b1, "R2");
        issue(enc_alt(4'd0, 4'd1, 5'd22, 5'd30), 1'b1, 32'h0F0F_0F0F, 32'h0000_01FF,
              1'b1, 4'd0, 4'd1, 22, 30, 1'b1, "R2");
        // R4: source bits above the field width are dropped.
        issue(enc_pri(4'hE, 5'd11, 4'd8, 5'd8, 4'd9), 1'b0, 32'h0000_0000, 32'hFFFF_FFFF,
              1'b1, 4'd9, 4'd8, 8, 11, 1'b1, "R4");
        // R5: condition failed, valid encoding: no write, no invalid.
        issue(enc_pri(4'hE, 5'd15, 4'd3, 5'd8, 4'd2), 1'b0, 32'h1234_5678, 32'h0000_00AB,
              1'b0, 4'd2, 4'd3, 8, 15, 1'b1, "R5");
        // R6: reversed field, both layouts.
        issue(enc_pri(4'hE, 5'd3, 4'd3, 5'd9, 4'd2), 1'b0, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 9, 3, 1'b1, "R6");
        issue(enc_alt(4'd2, 4'd3, 5'd20, 5'd19), 1'b1, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 20, 19, 1'b1, "R6");
        // R7: reserved source index, both layouts.
        issue(enc_pri(4'hE, 5'd15, 4'd3, 5'd8, 4'hF), 1'b0, 32'h0, 32'h0,
              1'b1, 4'hF, 4'd3, 8, 15, 1'b1, "R7");
        issue(enc_alt(4'hF, 4'd3, 5'd4, 5'd10), 1'b1, 32'h0, 32'h0,
              1'b1, 4'hF, 4'd3, 4, 10, 1'b1, "R7");
        // R8: broken fixed bits.
        issue(enc_pri(4'hE, 5'd15, 4'd3, 5'd8, 4'd2) ^ 32'h0000_0020, 1'b0, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 8, 15, 1'b0, "R8");
        issue(enc_pri(4'hE, 5'd15, 4'd3, 5'd8, 4'd2) ^ 32'h0020_0000, 1'b0, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 8, 15, 1'b0, "R8");
        issue(enc_alt(4'd2, 4'd3, 5'd4, 5'd10) | 32'h0000_8000, 1'b1, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 4, 10, 1'b0, "R8");
        issue(enc_alt(4'd2, 4'd3, 5'd4, 5'd10) | 32'h0000_0020, 1'b1, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 4, 10, 1'b0, "R8");
        // R8: a valid primary word presented as the alternate layout.
        issue(enc_pri(4'hE, 5'd15, 4'd3, 5'd8, 4'd2), 1'b1, 32'h0, 32'h0,
              1'b1, 4'd2, 4'd3, 8, 15, 1'b0, "R8");
        idle(3);
        // R9: no result without an input.
        report(out_valid == 1'b0, "R9", "out_valid idle", 32'(out_valid), 32'd0);
        report(sb_q.size() == 0, "R9", "results outstanding", 32'(sb_q.size()), 32'd0);
        finish_run();
    end
endmodule